// File: doc/BRIEF.md
# Landing Pad Control-Flow Guard

This block guards forward control-flow edges for a 32-bit core that runs both full-width and compressed instructions. It watches every instruction word as it retires. When an indirect jump retires that does not go through one of the conventional link registers, the block expects a landing pad at the jump target. It takes a 20-bit label from the upper bits of register x7 at that moment.

The next retiring instruction is then checked. It must be a landing-pad word on a word-aligned address, and its label must match the latched label or be the zero wildcard. If that check fails, the block raises a one-cycle software-check fault request with the landing-pad subcode. The core's trap logic turns that request into a trap. Checking only runs while the machine landing-pad enable input is high. That input mirrors bit 10 of the machine security configuration CSR (address 0x747), which the surrounding core holds.

Top module: `lp_guard`

## Requirements
- R1: After reset, `expect_pad`, `fault_req` and `fault_code` are all zero.
- R2: With `cfi_en` high, a retiring full-width word arms the expectation (`expect_pad` = 1 after that retire) when bits [6:0] = 0x67, bits [14:12] = 0 and rs1 (bits [19:15]) is not 1, 5 or 7.
- R3: With `cfi_en` high, a retiring compressed word arms the expectation when bits [1:0] = 2, bits [15:12] = 8 or 9 and bits [11:7] are not 1, 5 or 7.
- R4: An indirect jump whose rs1 is 1, 5 or 7, and any word that is not an indirect jump, leaves `expect_pad` at 0 after it retires.
- R5: When the expectation arms, bits [31:12] of `link_val` are latched as the label. A next retiring word with bits [11:0] = 0x017, PC bits [1:0] = 0 and bits [31:12] equal to the label passes: no fault, and the expectation clears.
- R6: A landing pad whose bits [31:12] are zero passes whatever the latched label is.
- R7: While the expectation is pending, a retiring word that is not a passing landing pad (wrong low 12 bits, PC not 4-byte aligned, or a label that differs and is not zero) sets `fault_req` for exactly one cycle, with `fault_code` = 2. `fault_code` is 0 whenever `fault_req` is 0.
- R8: With `cfi_en` low, a retire neither arms the expectation nor raises a fault, even when an expectation is pending. After such a retire `expect_pad` is 0.
- R9: In a cycle with `retire_vld` low, no state changes and `fault_req` is 0 on the next cycle.
- R10: Every retire recomputes the expectation from the retiring word alone. A checked word (passing or faulting) that is itself a qualifying indirect jump re-arms with the current `link_val` label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retire_vld | input | 1 | An instruction retires this cycle |
| insn | input | 32 | Retiring instruction word (upper half ignored by compressed decode) |
| pc | input | 32 | Address of the retiring instruction |
| link_val | input | 32 | Current value of register x7 |
| cfi_en | input | 1 | Machine landing-pad enable |
| expect_pad | output | 1 | A landing pad is expected on the next retire |
| fault_req | output | 1 | One-cycle software-check fault request |
| fault_code | output | 4 | Fault subcode, 2 for a landing-pad fault, else 0 |

## Verification
All three outputs come from registers, so each is due exactly one clock after the edge that samples a retiring word. `expect_pad`, `fault_req` and `fault_code` are all updated by that one edge. The bench drives a retire on a falling edge and lets one rising edge pass. It compares all three outputs at the following falling edge against a bench model that is advanced by that same retire. Idle cycles are checked the same way, one edge later, so the R9 hold is seen in the cycle where a wrong update would first show.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned LBL_W     = 20;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned REG_IDX_W = 5;

  localparam logic [6:0]  OPC_JALR  = 7'h67;
  localparam logic [11:0] PAD_LOW   = 12'h017;
  localparam logic [CODE_W-1:0] CODE_LP_FAULT = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_NONE     = '0;

  // Registers conventionally used for returns and linkage; jumps via them are exempt.
  function automatic logic is_link_reg(input logic [REG_IDX_W-1:0] r);
    return (r == 5'd1) || (r == 5'd5) || (r == 5'd7);
  endfunction
endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lp_arm_decode.sv
module lp_arm_decode
  import lp_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] insn,
  output logic         arm
);
  logic full_width;
  logic full_hit;
  logic cmp_hit;

  always_comb begin
    full_width = (insn[1:0] == 2'b11);
    full_hit   = full_width
               && (insn[6:0] == OPC_JALR)
               && (insn[14:12] == 3'd0)
               && !is_link_reg(insn[19:15]);
    cmp_hit    = (insn[1:0] == 2'b10)
               && ((insn[15:12] == 4'd8) || (insn[15:12] == 4'd9))
               && !is_link_reg(insn[11:7]);
    arm        = full_hit || cmp_hit;
  end

  // R4: a jump through a link register must never arm, whatever its width
  always_comb begin
    if (full_width && is_link_reg(insn[19:15])) a_link_full_r4: assert (!full_hit);
  end
endmodule

// File: rtl/lp_pad_match.sv
module lp_pad_match
  import lp_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned LW = LBL_W
) (
  input  logic [W-1:0]  insn,
  input  logic [W-1:0]  pc,
  input  logic [LW-1:0] label,
  output logic          pad_ok
);
  localparam int unsigned LO_W = W - LW;

  logic [LW-1:0] pad_lbl;
  logic          shape_ok;
  logic          align_ok;
  logic          lbl_ok;

  always_comb begin
    pad_lbl  = insn[W-1:LO_W];
    shape_ok = (insn[LO_W-1:0] == PAD_LOW);
    align_ok = (pc[1:0] == 2'b00);
    lbl_ok   = (pad_lbl == label) || (pad_lbl == '0);
    pad_ok   = shape_ok && align_ok && lbl_ok;
  end
endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire_vld,
  input  logic [XLEN-1:0]     insn,
  input  logic [XLEN-1:0]     pc,
  input  logic [XLEN-1:0]     link_val,
  input  logic                cfi_en,
  output logic                expect_pad,
  output logic                fault_req,
  output logic [CODE_W-1:0]   fault_code
);
  localparam int unsigned LO_W = XLEN - LBL_W;

  logic              rst_sync_n;
  logic              arm;
  logic              pad_ok;

  logic              expect_q, expect_d;
  logic [LBL_W-1:0]  label_q,  label_d;
  logic              fault_q,  fault_d;
  logic [CODE_W-1:0] code_q,   code_d;
  logic              state_en;

  lp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lp_arm_decode #(.W(XLEN)) u_arm (
    .insn (insn),
    .arm  (arm)
  );

  lp_pad_match #(.W(XLEN), .LW(LBL_W)) u_pad (
    .insn   (insn),
    .pc     (pc),
    .label  (label_q),
    .pad_ok (pad_ok)
  );

  // next-state
  always_comb begin
    state_en = retire_vld;
    expect_d = cfi_en && arm;
    label_d  = expect_d ? link_val[XLEN-1:LO_W] : label_q;
    fault_d  = retire_vld && cfi_en && expect_q && !pad_ok;
    code_d   = fault_d ? CODE_LP_FAULT : CODE_NONE;
  end

  // expectation state, written only on a retire
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      expect_q <= 1'b0;
      label_q  <= '0;
    end else if (state_en) begin
      expect_q <= expect_d;
      label_q  <= label_d;
    end
  end

  // fault pulse, recomputed every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_q <= 1'b0;
      code_q  <= CODE_NONE;
    end else begin
      fault_q <= fault_d;
      code_q  <= code_d;
    end
  end

  assign expect_pad = expect_q;
  assign fault_req  = fault_q;
  assign fault_code = code_q;

  // R7: a fault only follows a retire that found an expectation pending
  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_req |-> $past(retire_vld) && $past(expect_q) && $past(cfi_en));

  // R7: subcode tracks the request
  p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_req |-> (fault_code == CODE_LP_FAULT));

  p_code_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fault_req |-> (fault_code == CODE_NONE));

  // R9: nothing moves without a retire
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !retire_vld |=> $stable(expect_pad) && !fault_req);

  // R8: disabled checking neither arms nor faults
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire_vld && !cfi_en) |=> !expect_pad && !fault_req);

  // R5: a good pad on a pending expectation is accepted silently
  p_pad_pass_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire_vld && cfi_en && expect_q && pad_ok) |=> !fault_req);
endmodule

// File: tb/tb_lp_guard.sv
module tb_lp_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_vld;
  logic [31:0] insn, pc, link_val;
  logic        cfi_en;
  logic        expect_pad, fault_req;
  logic [3:0]  fault_code;

  int total = 0;
  int bad   = 0;

  logic        m_exp;
  logic [19:0] m_lbl;

  always #5 clk = ~clk;

  lp_guard dut (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .insn(insn), .pc(pc),
    .link_val(link_val), .cfi_en(cfi_en), .expect_pad(expect_pad),
    .fault_req(fault_req), .fault_code(fault_code)
  );

  function automatic bit linkish(input logic [4:0] r);
    return r == 5'd1 || r == 5'd5 || r == 5'd7;
  endfunction

  function automatic bit arms(input logic [31:0] w);
    if (w[1:0] == 2'b11)
      return w[6:0] == 7'h67 && w[14:12] == 3'b000 && !linkish(w[19:15]);
    if (w[1:0] == 2'b10)
      return (w[15:12] == 4'h8 || w[15:12] == 4'h9) && !linkish(w[11:7]);
    return 1'b0;
  endfunction

  function automatic bit pad_good(input logic [31:0] w, input logic [31:0] a,
                                  input logic [19:0] l);
    return w[11:0] == 12'h017 && a[1:0] == 2'b00 && (w[31:12] == l || w[31:12] == 20'd0);
  endfunction

  function automatic logic [31:0] mk_jalr(input logic [4:0] rs1, input logic [4:0] rd);
    return {12'h000, rs1, 3'b000, rd, 7'h67};
  endfunction

  function automatic logic [31:0] mk_cjr(input bit link, input logic [4:0] rs1);
    return {16'h0000, (link ? 4'h9 : 4'h8), rs1, 5'd0, 2'b10};
  endfunction

  function automatic logic [31:0] mk_pad(input logic [19:0] l);
    return {l, 12'h017};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies one cycle of stimulus, checks one edge later.
  task automatic step(input string req, input bit v, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] x7, input bit en);
    bit ef;
    retire_vld = v; insn = w; pc = a; link_val = x7; cfi_en = en;
    ef = 1'b0;
    if (v) begin
      ef = en && m_exp && !pad_good(w, a, m_lbl);
      m_exp = en && arms(w);
      if (m_exp) m_lbl = x7[31:12];
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "expect_pad", 32'(expect_pad), 32'(m_exp));
    chk(req, "fault_req",  32'(fault_req),  32'(ef));
    chk(req, "fault_code", 32'(fault_code), ef ? 32'd2 : 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; retire_vld = 0; insn = 0; pc = 0; link_val = 0; cfi_en = 0;
    m_exp = 0; m_lbl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "expect_pad", 32'(expect_pad), 0);
    chk("R1", "fault_req",  32'(fault_req), 0);
    chk("R1", "fault_code", 32'(fault_code), 0);

    // R2 full-width arm, R5 matching label passes
    step("R2", 1, mk_jalr(5'd10, 5'd0), 32'h100, 32'hABCDE123, 1);
    step("R5", 1, mk_pad(20'hABCDE), 32'h200, 32'h0, 1);
    // R3 compressed arm (c.jalr), R6 zero wildcard
    step("R3", 1, mk_cjr(1, 5'd12), 32'h102, 32'h12345000, 1);
    step("R6", 1, mk_pad(20'h0), 32'h300, 32'h0, 1);
    // R3 c.jr with rs1 = 0
    step("R3", 1, mk_cjr(0, 5'd0), 32'h104, 32'h55555000, 1);
    // R7 label mismatch
    step("R7", 1, mk_pad(20'h55554), 32'h400, 32'h0, 1);
    // R4 exempt registers, full-width and compressed
    step("R4", 1, mk_jalr(5'd1, 5'd0), 32'h500, 32'h0, 1);
    step("R4", 1, mk_jalr(5'd5, 5'd1), 32'h504, 32'h0, 1);
    step("R4", 1, mk_cjr(1, 5'd7), 32'h508, 32'h0, 1);
    step("R4", 1, {17'd0, 3'b001, 5'd0, 7'h67}, 32'h50C, 32'h0, 1);
    // R7 misaligned pad, then wrong low bits
    step("R2", 1, mk_jalr(5'd3, 5'd0), 32'h600, 32'hFEDCB000, 1);
    step("R7", 1, mk_pad(20'hFEDCB), 32'h602, 32'h0, 1);
    step("R2", 1, mk_jalr(5'd3, 5'd0), 32'h604, 32'hFEDCB000, 1);
    step("R7", 1, {20'hFEDCB, 12'h013}, 32'h700, 32'h0, 1);
    // R9 idle cycles hold state and produce no pulse
    step("R2", 1, mk_jalr(5'd4, 5'd0), 32'h704, 32'h11111000, 1);
    step("R9", 0, 32'h0, 32'h0, 32'h0, 1);
    step("R9", 0, 32'h13, 32'h2, 32'h0, 1);
    step("R5", 1, mk_pad(20'h11111), 32'h800, 32'h0, 1);
    // R10 faulting word that is itself a jump re-arms with new label
    step("R2", 1, mk_jalr(5'd6, 5'd0), 32'h900, 32'h22222000, 1);
    step("R10", 1, mk_jalr(5'd8, 5'd0), 32'hA00, 32'h33333000, 1);
    step("R10", 1, mk_pad(20'h22222), 32'hB00, 32'h0, 1);
    // R8 disabled: no check of pending, no arm
    step("R2", 1, mk_jalr(5'd9, 5'd0), 32'hC00, 32'h44444000, 1);
    step("R8", 1, 32'h00000013, 32'hC04, 32'h0, 0);
    step("R8", 1, mk_jalr(5'd9, 5'd0), 32'hC08, 32'h0, 0);
    step("R8", 1, 32'h00000013, 32'hC0C, 32'h0, 1);

    // R10 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w, a, x;
      int k;
      k = $urandom_range(0, 7);
      x = $urandom;
      a = {$urandom, 1'b0} & 32'hFFFF_FFFE;
      if ($urandom_range(0, 3) == 0) a[1] = 1'b1; else a[1] = 1'b0;
      case (k)
        0, 1: w = mk_jalr(5'($urandom_range(0, 9)), 5'($urandom));
        2:    w = mk_cjr($urandom_range(0, 1) == 1, 5'($urandom_range(0, 9)));
        3:    w = mk_pad(m_lbl);
        4:    w = mk_pad(20'd0);
        5:    w = mk_pad(20'($urandom_range(0, 3)));
        default: w = $urandom;
      endcase
      if (k == 3 && $urandom_range(0, 1) == 1) x[31:12] = m_lbl;
      step("R10", $urandom_range(0, 5) != 0, w, a, x, $urandom_range(0, 9) != 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule